// File: doc/BRIEF.md
# Auxiliary Video Packet Buffer Scheduler

This block holds three auxiliary video packet images (AVI, vendor and SPD) and replays them as byte streams when vertical sync arrives. Software programs it through a small register write port. A control write sets a global enable, an output port code, one transmit enable per packet type, which buffer is being loaded, and a repeat rate. Data writes carry 32-bit words, and each one goes into the next word of the selected buffer.

On each `vsync` pulse the block works out which enabled buffers are due. A buffer is due only if it has been completely written since its last reload, and the rule depends on the repeat rate: send once, send every sync, or send every second sync. It queues the due buffers and streams them one after another over a valid/ready byte interface, in the fixed order AVI, vendor, SPD. Each packet image is sent whole (header, reserved byte, checksum, payload, padding) with the first-loaded byte first. The software supplies the checksum byte so that the 8-bit sum of the packet bytes is zero.

Top module: `aux_pkt_sched`

## Requirements
- R1: Control word fields: bit 31 is the global enable and bits 30:29 are the port code. The transmit enables are bit 21 (AVI), bit 22 (vendor) and bit 24 (SPD). Bits 20:19 select the buffer to load (0 AVI, 1 vendor, 3 SPD). Bits 17:16 set the rate. The port code in force when a packet starts is shown on `out_port` for the whole packet.
- R2: A data write (`wr_is_data`=1) stores `wr_data` as the next word of the selected buffer. A packet streams all BUF_WORDS*4 bytes, taking bytes 7:0 of word 0 first and working upward. `out_last` is high only on the final byte, and `out_type` gives 0 AVI, 1 vendor or 2 SPD.
- R3: A control write resets the word pointer of the buffer it selects. Data writes beyond BUF_WORDS words are ignored, and data writes while the select code is 2 are ignored.
- R4: A buffer is emitted only when all of its words have been written since its last reload started. A partly loaded buffer is never sent.
- R5: Rate 1 sends an enabled, complete buffer on every vsync.
- R6: Rate 0 sends a buffer once after its enable is written from 0 to 1. It sends again only after the enable is rewritten from 0 to 1.
- R7: Rate 2 sends on the first vsync after the global enable is set, and then on every second vsync. The alternation phase is held at zero while the global enable is low.
- R8: Buffers that are due on the same vsync are sent back to back in the order AVI, vendor, SPD.
- R9: While the global enable is low, no packet is started and queued packets are dropped.
- R10: While `out_valid` is high and `out_ready` is low, the data, last, type and port outputs stay unchanged.
- R11: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_is_data | input | 1 | 1 = data word write, 0 = control write |
| wr_data | input | 32 | Write value |
| vsync | input | 1 | One-cycle vertical sync pulse |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | 8 | Packet byte |
| out_last | output | 1 | Final byte of packet |
| out_type | output | 2 | Buffer being sent |
| out_port | output | 2 | Port code latched at packet start |

## Verification
The assertions take two things for granted. Software does not write into a buffer while that buffer is being streamed. And `vsync` is a single-cycle pulse that arrives only after the control write that arms a buffer has completed. The stimulus respects both. Every reload is done with that type's enable cleared, or while the stream is idle, and every sync pulse comes only after the previous packets have drained. Back-pressure on `out_ready` is applied only through the consumer handshake, which leaves the buffer contents untouched while a stall is held.

// File: rtl/aux_pkt_sched.sv
module aux_pkt_sched #(
  parameter int BUF_WORDS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_is_data,
  input  logic [31:0] wr_data,
  input  logic        vsync,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic [1:0]  out_type,
  output logic [1:0]  out_port
);
  localparam int NBYTES = BUF_WORDS * 4;
  localparam int PW     = $clog2(BUF_WORDS + 1);
  localparam int BW     = $clog2(NBYTES);

  logic        gen_q, phase;
  logic [1:0]  port_q, sel_q, freq_q, cur, port_o;
  logic [2:0]  ten_q, pend, queue, full, due, grant, pend_set, pend_clr;
  logic        busy;
  logic [BW-1:0] bidx;
  logic [PW-1:0] ptr [3];
  logic [31:0]   mem [3][BUF_WORDS];

  wire ctl_wr = wr_en & ~wr_is_data;
  wire dat_wr = wr_en & wr_is_data;
  wire [2:0] ten_new = {wr_data[24], wr_data[22], wr_data[21]};
  wire [1:0] nsel    = (wr_data[20:19] == 2'd3) ? 2'd2 : wr_data[20:19];
  wire       nsel_ok = wr_data[20:19] != 2'd2;
  wire [1:0] bsel    = (sel_q == 2'd3) ? 2'd2 : sel_q;
  wire       bsel_ok = sel_q != 2'd2;
  wire       ld_ok   = dat_wr && bsel_ok && (ptr[bsel] < PW'(BUF_WORDS));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gen_q <= 1'b0; port_q <= '0; ten_q <= '0; sel_q <= '0; freq_q <= '0;
    end else if (ctl_wr) begin
      gen_q  <= wr_data[31];
      port_q <= wr_data[30:29];
      ten_q  <= ten_new;
      sel_q  <= wr_data[20:19];
      freq_q <= wr_data[17:16];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) ptr[i] <= '0;
      full <= '0;
    end else if (ctl_wr) begin
      if (nsel_ok) ptr[nsel] <= '0;
    end else if (ld_ok) begin
      ptr[bsel]  <= ptr[bsel] + 1'b1;
      full[bsel] <= (ptr[bsel] == PW'(BUF_WORDS - 1));
    end

  always_ff @(posedge clk)
    if (ld_ok) mem[bsel][ptr[bsel][BW-3:0]] <= wr_data;

  always_comb
    for (int i = 0; i < 3; i++)
      due[i] = vsync && gen_q && ten_q[i] && full[i] &&
               ((freq_q == 2'd0 && pend[i]) || freq_q == 2'd1 ||
                (freq_q == 2'd2 && !phase));

  assign pend_set = ctl_wr ? (ten_new & ~ten_q) : 3'b000;
  assign pend_clr = (freq_q == 2'd0) ? due : 3'b000;

  assign grant = queue[0] ? 3'b001 : queue[1] ? 3'b010 : queue[2] ? 3'b100 : 3'b000;
  wire fin   = out_valid && out_ready && out_last;
  wire start = gen_q && (|queue) && (!busy || fin);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend <= '0; phase <= 1'b0; queue <= '0;
    end else begin
      pend  <= (pend & ~pend_clr) | pend_set;
      phase <= gen_q ? (phase ^ vsync) : 1'b0;
      queue <= gen_q ? ((queue & ~(start ? grant : 3'b000)) | due) : 3'b000;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; cur <= '0; bidx <= '0; port_o <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cur    <= grant[0] ? 2'd0 : grant[1] ? 2'd1 : 2'd2;
      bidx   <= '0;
      port_o <= port_q;
    end else if (fin) begin
      busy <= 1'b0;
    end else if (out_valid && out_ready) begin
      bidx <= bidx + 1'b1;
    end

  wire [31:0] word = mem[cur][bidx[BW-1:2]];
  assign out_valid = busy;
  assign out_data  = word[{bidx[1:0], 3'b000} +: 8];
  assign out_last  = busy && (bidx == BW'(NBYTES - 1));
  assign out_type  = cur;
  assign out_port  = port_o;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)
                                   && $stable(out_type) && $stable(out_port)));
  p_gen_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_q && !busy) |=> !out_valid);
  p_phase_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q |=> !phase);
  p_full_emit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && bidx == '0) |-> full[cur]);
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!out_valid || bidx == '0));
endmodule

// File: tb/tb_aux_pkt_sched.sv
`timescale 1ns/1ps
module tb_aux_pkt_sched;
  localparam int BWD = 5;
  localparam int NB  = BWD * 4;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_is_data = 0, vsync = 0, out_ready = 1;
  logic [31:0] wr_data = '0;
  logic out_valid, out_last;
  logic [7:0] out_data;
  logic [1:0] out_type, out_port;

  aux_pkt_sched #(.BUF_WORDS(BWD)) dut (.*);

  always #4 clk = ~clk;

  typedef struct { logic [7:0] d; logic l; logic [1:0] t; logic [1:0] p; int req; } item_t;
  item_t expq[$];
  logic [7:0] sh [3][NB];
  int total = 0, bad = 0, cyc = 0, cur_req = 0;
  bit stall = 0;

  always @(posedge clk) begin
    cyc++;
    #1 out_ready = stall ? (cyc % 3 != 0) : 1'b1;
  end

  logic hold_v = 0;
  logic [7:0] hold_d;
  always @(negedge clk) if (rst_n) begin
    if (hold_v) begin
      total++;
      if (!(out_valid && out_data == hold_d)) begin
        bad++;
        $display("FAIL R10 stall hold: valid=%0b data=%h expected valid=1 data=%h", out_valid, out_data, hold_d);
      end
    end
    hold_v = out_valid && !out_ready;
    hold_d = out_data;
    if (out_valid && out_ready) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R%0d unexpected byte: type=%0d data=%h expected none", cur_req, out_type, out_data);
      end else begin
        item_t e;
        e = expq.pop_front();
        if (out_data !== e.d || out_last !== e.l || out_type !== e.t || out_port !== e.p) begin
          bad++;
          $display("FAIL R%0d byte: data=%h last=%0b type=%0d port=%0d expected data=%h last=%0b type=%0d port=%0d",
                   e.req, out_data, out_last, out_type, out_port, e.d, e.l, e.t, e.p);
        end
      end
    end
  end

  function automatic logic [31:0] cw(bit gen, logic [1:0] port, logic [2:0] ten, logic [1:0] sel, logic [1:0] fr);
    return (32'(gen) << 31) | (32'(port) << 29) | (32'(ten[0]) << 21) | (32'(ten[1]) << 22)
         | (32'(ten[2]) << 24) | (32'(sel) << 19) | (32'(fr) << 16);
  endfunction

  task automatic wr(input logic d, input logic [31:0] v);
    wr_en = 1; wr_is_data = d; wr_data = v;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic ctl(bit gen, logic [1:0] port, logic [2:0] ten, logic [1:0] sel, logic [1:0] fr);
    wr(1'b0, cw(gen, port, ten, sel, fr));
  endtask

  task automatic load(int t, int seed, int nw);
    logic [7:0] b [NB];
    logic [7:0] sum;
    b[0] = 8'h81 + 8'(t == 0 ? 1 : t == 1 ? 0 : 2);
    b[1] = 8'h02; b[2] = 8'd13; b[3] = 8'h00; b[4] = 8'h00;
    for (int i = 5; i < NB; i++) b[i] = (i >= NB - 2) ? 8'h00 : 8'(seed + i * 7 + t * 29);
    sum = 0;
    for (int i = 0; i < NB; i++) sum += b[i];
    b[4] = 8'h00 - sum;
    for (int k = 0; k < nw; k++) begin
      if (k < BWD) begin
        for (int j = 0; j < 4; j++) sh[t][4*k+j] = b[4*k+j];
        wr(1'b1, {b[4*k+3], b[4*k+2], b[4*k+1], b[4*k]});
      end else wr(1'b1, 32'hDEAD_0000 + 32'(k));
    end
  endtask

  task automatic vs();
    vsync = 1; @(posedge clk); #1; vsync = 0;
  endtask

  task automatic expect_pkt(int t, logic [1:0] port, int req);
    for (int i = 0; i < NB; i++) begin
      item_t e;
      e.d = sh[t][i]; e.l = (i == NB - 1); e.t = 2'(t); e.p = port; e.req = req;
      expq.push_back(e);
    end
  endtask

  task automatic drain();
    int n = 0;
    while (!(expq.size() == 0 && !out_valid) && n < 3000) begin @(negedge clk); n++; end
    repeat (8) @(posedge clk);
    #1;
    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL R%0d missing bytes: left=%0d expected 0", cur_req, expq.size());
      expq.delete();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin bad++; $display("FAIL R11 reset: out_valid=%b expected 0", out_valid); end
    @(posedge clk); #1;

    // R1 R2 R5: AVI on port 1, every vsync
    cur_req = 5;
    ctl(1, 2'd1, 3'b000, 2'd0, 2'd1);
    load(0, 3, BWD);
    ctl(1, 2'd1, 3'b001, 2'd0, 2'd1);
    vs(); expect_pkt(0, 2'd1, 2); drain();
    vs(); expect_pkt(0, 2'd1, 5); drain();

    // R6: vendor once on port 2
    cur_req = 6;
    ctl(1, 2'd2, 3'b000, 2'd1, 2'd0);
    load(1, 40, BWD);
    ctl(1, 2'd2, 3'b010, 2'd1, 2'd0);
    vs(); expect_pkt(1, 2'd2, 6); drain();
    vs(); drain();
    ctl(1, 2'd2, 3'b000, 2'd1, 2'd0);
    ctl(1, 2'd2, 3'b010, 2'd1, 2'd0);
    vs(); expect_pkt(1, 2'd2, 6); drain();

    // R8 R10: all three due together, consumer stalls
    cur_req = 8;
    ctl(1, 2'd1, 3'b000, 2'd3, 2'd1);
    load(2, 90, BWD);
    ctl(1, 2'd1, 3'b111, 2'd3, 2'd1);
    stall = 1;
    vs(); expect_pkt(0, 2'd1, 8); expect_pkt(1, 2'd1, 8); expect_pkt(2, 2'd1, 8); drain();
    stall = 0;

    // R9: global enable low
    cur_req = 9;
    ctl(0, 2'd1, 3'b111, 2'd3, 2'd1);
    vs(); drain();
    vs(); drain();

    // R7: every second vsync, phase restarts from global enable
    cur_req = 7;
    ctl(1, 2'd1, 3'b001, 2'd0, 2'd2);
    vs(); expect_pkt(0, 2'd1, 7); drain();
    vs(); drain();
    vs(); expect_pkt(0, 2'd1, 7); drain();
    ctl(0, 2'd1, 3'b001, 2'd0, 2'd2);
    ctl(1, 2'd1, 3'b001, 2'd0, 2'd2);
    vs(); expect_pkt(0, 2'd1, 7); drain();

    // R3: overflow writes ignored, select code 2 ignored
    cur_req = 3;
    ctl(1, 2'd1, 3'b000, 2'd0, 2'd1);
    load(0, 150, BWD + 2);
    ctl(1, 2'd1, 3'b001, 2'd0, 2'd1);
    vs(); expect_pkt(0, 2'd1, 3); drain();
    ctl(1, 2'd1, 3'b000, 2'd2, 2'd1);
    for (int k = 0; k < BWD; k++) wr(1'b1, 32'hBAD0_0000 + 32'(k));
    ctl(1, 2'd1, 3'b001, 2'd0, 2'd1);
    vs(); expect_pkt(0, 2'd1, 3); drain();

    // R4: partial SPD buffer not sent; completed reload sent
    cur_req = 4;
    ctl(1, 2'd3, 3'b000, 2'd3, 2'd1);
    load(2, 210, 2);
    ctl(1, 2'd3, 3'b100, 2'd3, 2'd1);
    vs(); drain();
    load(2, 210, BWD);
    vs(); expect_pkt(2, 2'd3, 4); drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    bad++; total++;
    $display("FAIL R11 watchdog: cycles=%0d expected completion", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule